// File: doc/BRIEF.md
# PSRAM Synchronous Burst Write Engine

This block is the host-side sequencer that writes a burst of 16-bit words into a pseudo-static RAM whose low address bits share the data pins. A requester presents a start address together with a latency setting and a burst-length code. The engine accepts the request only while idle. It then spends one command cycle with chip select, address valid and write enable low, so that the memory latches the address on that rising edge. After that it holds address valid high, waits out the configured latency, and streams the data words on back-to-back clocks.

Write data arrives on a ready/valid stream with per-byte enables. The byte enables become the active-low upper and lower byte strobes of each word, so they work as a write mask. If the stream has no word ready in a data slot, the engine masks both bytes in that slot instead of stalling the memory. When the last slot has been sent, the engine removes chip select and the memory clock enable for one cycle and pulses `done` in that cycle. It is idle again on the following cycle.

The write latency is fixed, so the engine takes no wait signal from the memory. Output enable stays high and the control-register select stays low throughout.

Top module: `psram_bwr_engine`

## Requirements
- R1: After reset, and whenever idle, the engine drives chip select, address valid, write enable and output enable high, register select low, both byte strobes high, memory clock enable low, the bus undriven (`mem_ad_oe`=0, `mem_ad_out`=0), `done` and `wd_ready` low, and `req_ready` high.
- R2: The cycle after a request is accepted (`req_valid` while `req_ready`) is the command cycle. In it chip select, address valid and write enable are low, output enable is high, register select is low, the clock enable is high, the bus carries the start address bits [15:0] with `mem_ad_oe`=1, `mem_addr_hi` carries address bits [22:16], and both byte strobes are high.
- R3: Address valid is low for exactly one cycle per burst. From the command cycle to the last data slot, chip select stays low and the clock enable stays high.
- R4: The cycles between the command cycle and the first data slot leave the bus undriven (`mem_ad_out`=0) with both byte strobes high and `wd_ready` low.
- R5: The first data slot is the L-th cycle after the command cycle, where L is the effective latency. Later slots follow on consecutive cycles. In every slot `wd_ready`=1, `mem_ad_oe`=1, address valid is high and `mem_ad_out` equals `wd_data`.
- R6: Burst code values 0, 1, 2 and 3 give exactly 4, 8, 16 and 32 data slots. `wd_last` has no effect in these modes.
- R7: Any burst code with bit 2 set selects continuous mode. The burst ends with the first slot in which `wd_valid` and `wd_last` are both high. A `wd_last` without `wd_valid` does not end it.
- R8: In a slot with `wd_valid`=1, `mem_be_n` = ~`wd_be`. Bit 1 is the upper byte and bit 0 is the lower byte.
- R9: In a slot with `wd_valid`=0, both byte strobes are high (the whole word is masked). The slot still counts toward the burst length.
- R10: The cycle after the last slot has chip select high, the clock enable low and `done`=1 for that one cycle. The engine is idle on the next cycle. Requests made while busy are ignored and are not accepted later.
- R11: The latency input is clamped: values below 2 act as 2, values above 8 act as 8, and values from 2 to 8 are used as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request |
| req_addr | input | 23 | Burst start word address |
| cfg_latency | input | 4 | Latency in clocks (clamped 2..8) |
| cfg_burst | input | 3 | Burst code: 0..3 give 4/8/16/32 words, bit 2 selects continuous |
| req_ready | output | 1 | Engine idle, request can be accepted |
| wd_valid | input | 1 | Write word present |
| wd_data | input | 16 | Write word |
| wd_be | input | 2 | Byte enables, bit 1 upper |
| wd_last | input | 1 | Final word (continuous mode only) |
| wd_ready | output | 1 | Data slot open this cycle |
| done | output | 1 | Burst finished pulse |
| mem_clk_en | output | 1 | Memory clock enable |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_cre | output | 1 | Control-register select |
| mem_be_n | output | 2 | Byte strobes, active low, bit 1 upper |
| mem_ad_out | output | 16 | Shared address/data bus value |
| mem_ad_oe | output | 1 | Shared bus drive enable |
| mem_addr_hi | output | 7 | Upper address bits |

## Verification
Bursts are run for every fixed length code at latencies 2, 3, 5 and 8, with the pins compared in each cycle. This tells apart an off-by-one in the wait count from an off-by-one in the slot count, because each shows up as a word in the wrong cycle or a late or early `done`. Stall patterns at the first, middle and last slots separate a correct per-slot mask from a design that stretches the burst or leaks stale strobes. In the fixed-length runs `wd_last` is raised early to show it has no effect. The continuous-mode runs place `wd_last` on a stalled slot before the real one. Out-of-range latency codes 0 and 15 show the clamp. Requests held high through a whole burst show that the engine ignores requests while busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP,
    ST_DATA,
    ST_TAIL
  } pwb_state_e;

  // Effective latency: raw setting forced into [lo, hi].
  function automatic int clamp_latency(input int raw, input int lo, input int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Fixed burst length from the two low code bits: 4 << code.
  function automatic int burst_slots(input logic [1:0] code);
    return 4 << code;
  endfunction
endpackage

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int LAT_W   = 4,
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 8,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic [2:0]       cfg_burst,
  input  logic             wd_valid,
  input  logic             wd_last,
  output pwb_state_e       state,
  output logic             accept,
  output logic             last_slot
);
  logic [CNT_W-1:0] cnt;
  logic [2:0]       burst_q;
  logic             end_burst;
  int               lat_eff;

  assign lat_eff   = clamp_latency(int'(cfg_latency), LAT_MIN, LAT_MAX);
  assign accept    = (state == ST_IDLE) && req_valid;
  assign end_burst = burst_q[2] ? (wd_valid && wd_last) : (cnt == CNT_W'(1));
  assign last_slot = (state == ST_DATA) && end_burst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      burst_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_CMD;
          cnt     <= CNT_W'(lat_eff - 1);
          burst_q <= cfg_burst;
        end
        ST_CMD: state <= ST_GAP;
        ST_GAP: begin
          if (cnt == CNT_W'(1)) begin
            state <= ST_DATA;
            cnt   <= CNT_W'(burst_slots(burst_q[1:0]));
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DATA: begin
          cnt <= cnt - 1'b1;
          if (end_burst) state <= ST_TAIL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwb_pins.sv
module pwb_pins
  import pwb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  pwb_state_e        state,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  input  logic [BE_W-1:0]   wd_be,
  output logic              mem_clk_en,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic              mem_we_n,
  output logic [BE_W-1:0]   mem_be_n,
  output logic [DATA_W-1:0] mem_ad_out,
  output logic              mem_ad_oe,
  output logic              wd_ready,
  output logic              done,
  output logic              req_ready
);
  always_comb begin
    mem_clk_en = 1'b0;
    mem_ce_n   = 1'b1;
    mem_adv_n  = 1'b1;
    mem_we_n   = 1'b1;
    mem_be_n   = '1;
    mem_ad_out = '0;
    mem_ad_oe  = 1'b0;
    wd_ready   = 1'b0;
    done       = 1'b0;
    req_ready  = 1'b0;
    case (state)
      ST_IDLE: req_ready = 1'b1;
      ST_CMD: begin
        mem_clk_en = 1'b1;
        mem_ce_n   = 1'b0;
        mem_adv_n  = 1'b0;
        mem_we_n   = 1'b0;
        mem_ad_out = addr_lo;
        mem_ad_oe  = 1'b1;
      end
      ST_GAP: begin
        mem_clk_en = 1'b1;
        mem_ce_n   = 1'b0;
      end
      ST_DATA: begin
        mem_clk_en = 1'b1;
        mem_ce_n   = 1'b0;
        mem_ad_out = wd_data;
        mem_ad_oe  = 1'b1;
        wd_ready   = 1'b1;
        mem_be_n   = wd_valid ? ~wd_be : '1;
      end
      default: done = 1'b1;
    endcase
  end
endmodule

// File: rtl/psram_bwr_engine.sv
module psram_bwr_engine
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int DATA_W    = 16,
  parameter int BE_W      = DATA_W / 8,
  parameter int LAT_W     = 4,
  parameter int LAT_MIN   = 2,
  parameter int LAT_MAX   = 8,
  parameter int MAX_BURST = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LAT_W-1:0]         cfg_latency,
  input  logic [2:0]               cfg_burst,
  output logic                     req_ready,
  input  logic                     wd_valid,
  input  logic [DATA_W-1:0]        wd_data,
  input  logic [BE_W-1:0]          wd_be,
  input  logic                     wd_last,
  output logic                     wd_ready,
  output logic                     done,
  output logic                     mem_clk_en,
  output logic                     mem_ce_n,
  output logic                     mem_adv_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic                     mem_cre,
  output logic [BE_W-1:0]          mem_be_n,
  output logic [DATA_W-1:0]        mem_ad_out,
  output logic                     mem_ad_oe,
  output logic [ADDR_W-DATA_W-1:0] mem_addr_hi
);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  pwb_state_e        state;
  logic              accept_w;
  logic              last_slot_w;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (accept_w) addr_q <= req_addr;
  end

  assign mem_oe_n    = 1'b1;
  assign mem_cre     = 1'b0;
  assign mem_addr_hi = addr_q[ADDR_W-1:DATA_W];

  pwb_seq #(
    .LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cfg_latency(cfg_latency), .cfg_burst(cfg_burst),
    .wd_valid(wd_valid), .wd_last(wd_last),
    .state(state), .accept(accept_w), .last_slot(last_slot_w)
  );

  pwb_pins #(.DATA_W(DATA_W), .BE_W(BE_W)) pins_i (
    .state(state), .addr_lo(addr_q[DATA_W-1:0]),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_be(wd_be),
    .mem_clk_en(mem_clk_en), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_ad_out(mem_ad_out),
    .mem_ad_oe(mem_ad_oe), .wd_ready(wd_ready), .done(done),
    .req_ready(req_ready)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int BE_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            last_slot,
  input logic            wd_ready,
  input logic            wd_valid,
  input logic            done,
  input logic            mem_clk_en,
  input logic            mem_ce_n,
  input logic            mem_adv_n,
  input logic            mem_we_n,
  input logic            mem_oe_n,
  input logic            mem_cre,
  input logic [BE_W-1:0] mem_be_n
);
  assert_cmd_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!mem_ce_n && !mem_we_n && mem_oe_n && !mem_cre && mem_clk_en));

  assert_accept_to_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_adv_n);

  assert_adv_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);

  assert_slot_adv_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> (mem_adv_n && !mem_ce_n && mem_clk_en));

  assert_stall_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ready && !wd_valid) |-> (mem_be_n == '1));

  assert_last_to_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last_slot |=> done);

  assert_done_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_ce_n && !mem_clk_en && !wd_ready));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind psram_bwr_engine pwb_checker #(.BE_W(BE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept_w), .last_slot(last_slot_w),
  .wd_ready(wd_ready), .wd_valid(wd_valid), .done(done),
  .mem_clk_en(mem_clk_en), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_cre(mem_cre),
  .mem_be_n(mem_be_n)
);

// File: tb/psram_bwr_engine_tb.sv
`timescale 1ns/1ps
module psram_bwr_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [22:0] req_addr;
  logic [3:0]  cfg_latency;
  logic [2:0]  cfg_burst;
  logic        req_ready;
  logic        wd_valid;
  logic [15:0] wd_data;
  logic [1:0]  wd_be;
  logic        wd_last;
  logic        wd_ready, done;
  logic        mem_clk_en, mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, mem_cre;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_ad_out;
  logic        mem_ad_oe;
  logic [6:0]  mem_addr_hi;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  psram_bwr_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_latency(cfg_latency), .cfg_burst(cfg_burst), .req_ready(req_ready),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_be(wd_be), .wd_last(wd_last),
    .wd_ready(wd_ready), .done(done), .mem_clk_en(mem_clk_en),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_cre(mem_cre), .mem_be_n(mem_be_n),
    .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe), .mem_addr_hi(mem_addr_hi)
  );

  // Pin snapshot: clk_en ce adv we oe cre be[1:0] ad_oe ad[15:0] done wd_ready req_ready
  function automatic logic [28:0] pins();
    return {mem_clk_en, mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, mem_cre,
            mem_be_n, mem_ad_oe, mem_ad_out, done, wd_ready, req_ready};
  endfunction

  function automatic logic [28:0] want(logic ck, logic ce, logic adv, logic we,
                                       logic [1:0] be, logic oe_bus, logic [15:0] ad,
                                       logic dn, logic rdy, logic rq);
    return {ck, ce, adv, we, 1'b1, 1'b0, be, oe_bus, ad, dn, rdy, rq};
  endfunction

  task automatic chk(string tag, logic [28:0] act, logic [28:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  localparam logic [28:0] IDLE_V = {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1};

  // One burst, checked cycle by cycle.
  task automatic run_burst(string name, logic [22:0] addr, logic [3:0] lat,
                           logic [2:0] code, int exp_lat, int exp_slots,
                           logic [31:0] stall, logic [31:0] lastm, bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; cfg_latency = lat; cfg_burst = code;
    #1 chk({name, " R1 idle before request"}, pins(), IDLE_V);
    @(negedge clk);
    req_valid = poke; req_addr = ~addr; cfg_latency = 4'd2; cfg_burst = 3'd0;
    #1 chk({name, " R2 command cycle"}, pins(),
           want(1, 0, 0, 0, 2'b11, 1, addr[15:0], 0, 0, 0));
    chk({name, " R2 upper address"}, 29'(mem_addr_hi), 29'(addr[22:16]));
    for (int c = 1; c < exp_lat; c++) begin
      @(negedge clk);
      #1 chk({name, " R4 latency gap"}, pins(),
             want(1, 0, 1, 1, 2'b11, 0, 16'h0, 0, 0, 0));
    end
    for (int j = 0; j < exp_slots; j++) begin
      logic [1:0] be;
      be = (j % 3 == 1) ? 2'b01 : ((j % 3 == 2) ? 2'b10 : 2'b11);
      @(negedge clk);
      wd_valid = !stall[j];
      wd_data  = {addr[7:0] ^ 8'(j), 8'(j * 7 + 1)};
      wd_be    = be;
      wd_last  = lastm[j];
      #1 chk({name, stall[j] ? " R9 stalled slot" : " R5 R8 data slot"}, pins(),
             want(1, 0, 1, 1, stall[j] ? 2'b11 : ~be, 1, wd_data, 0, 1, 0));
    end
    @(negedge clk);
    wd_valid = 1'b0; wd_last = 1'b0; req_valid = 1'b0;
    #1 chk({name, " R6 R7 R10 tail after last slot"}, pins(),
           want(0, 1, 1, 1, 2'b11, 0, 16'h0, 1, 0, 0));
    @(negedge clk);
    #1 chk({name, " R10 idle, busy request ignored"}, pins(), IDLE_V);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; cfg_latency = 4'd2;
    cfg_burst = 3'd0; wd_valid = 1'b0; wd_data = '0; wd_be = '0; wd_last = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1 pins held in reset", pins(), IDLE_V);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 idle after reset", pins(), IDLE_V);

    // R6 fixed lengths; early wd_last ignored
    run_burst("len4 lat3", 23'h5A_1234, 4'd3, 3'd0, 3, 4, 32'h0, 32'h2, 1'b0);
    run_burst("len8 lat2", 23'h7F_FFFE, 4'd2, 3'd1, 2, 8, 32'h24, 32'h1, 1'b1);
    run_burst("len16 lat8", 23'h00_0001, 4'd8, 3'd2, 8, 16, 32'h8001, 32'h0, 1'b0);
    run_burst("len32 lat5", 23'h2B_C0DE, 4'd5, 3'd3, 5, 32, 32'h4000_0010, 32'h10, 1'b1);
    // R7 continuous: last on stalled slot 2 ignored, real end at slot 6
    run_burst("cont lat4", 23'h11_AAAA, 4'd4, 3'b100, 4, 7, 32'h24, 32'h44, 1'b0);
    // R11 clamp low and high
    run_burst("R11 lat0", 23'h33_5555, 4'd0, 3'd0, 2, 4, 32'h0, 32'h0, 1'b0);
    run_burst("R11 lat15 cont", 23'h44_0F0F, 4'd15, 3'b111, 8, 1, 32'h0, 32'h1, 1'b1);
    // back-to-back with no idle padding beyond the required cycle
    run_burst("R10 back-to-back", 23'h55_8000, 4'd2, 3'd0, 2, 4, 32'h8, 32'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog R10 actual=no completion expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule